// File: doc/BRIEF.md
# Command Frame Address Completion and Reset Decoder

This block sits behind an Ethernet MAC controller. The controller strips the preamble and start-frame delimiter and then passes each received frame as a byte stream. The stream begins at the destination address. A byte is transferred on each clock edge where `in_valid` is high, and `in_last` marks the final byte of a frame. The controller's own address filter compares only five of the six destination address bytes. This block compares the remaining sixth byte, at byte index 5, against the local station's last address byte. A frame that fails this comparison draws a one-cycle skip request, and nothing else in it has any effect.

For a frame that passes, the block does not interpret the 14-byte header (both addresses and the length field). The byte at index 14 is a command code written as an ASCII letter. A reset command ('R', 0x52) carries a flag byte at index 15, and each of its low four bits asks for one board device to be reset. When the frame ends, the block emits one-cycle reset pulses for the flagged devices, together with a request to send an initialization-complete reply. The reply is requested even when no flag is set, so the command can also be used as a liveness probe. Any other command code is passed on with a one-cycle valid strobe for other logic to handle.

Top module: `cmd_rx_decoder`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, `skip_req`, `reply_req` and `cmd_valid` are low, `rst_pulse` is zero and `cmd_code` is 0x00.
- R2: If the byte at index 5 of a frame differs from `local_mac_lsb`, `skip_req` is high for exactly one cycle, in the cycle right after that byte is accepted. A frame whose byte at index 5 matches, or a frame shorter than 6 bytes, raises no skip request.
- R3: A frame that draws a skip request produces no `rst_pulse`, `reply_req` or `cmd_valid`, whatever its later bytes hold.
- R4: The values of the bytes at indexes 0–4 and 6–13 have no effect on any output.
- R5: For a matching frame with code 0x52 at index 14 and a flag byte at index 15, `reply_req` is high for one cycle in the cycle after the last byte is accepted. In the same cycle `rst_pulse` equals bits 3:0 of the flag byte: bit 0 is the Ethernet controller, bit 1 the ADC, bit 2 the temperature sensor and bit 3 the DAC. Bits 7:4 of the flag byte are ignored.
- R6: A reset command whose flag bits 3:0 are all zero still raises `reply_req` for one cycle, and `rst_pulse` stays zero.
- R7: Bytes at index 16 and above are padding and do not change any output.
- R8: A frame that ends before index 14, or that carries code 0x52 and ends at index 14, raises no output.
- R9: For a matching frame of at least 15 bytes whose code is not 0x52, `cmd_valid` is high for one cycle in the cycle after the last byte, with `cmd_code` equal to the code. No reset pulse or reply request is raised, and `cmd_code` holds its value until the next strobe.
- R10: Cycles where `in_valid` is low transfer no byte and do not advance the byte index. The byte after an accepted `in_last` is index 0 of the next frame.
- R11: `cmd_valid` and `reply_req` are never high together, and a nonzero `rst_pulse` only occurs together with `reply_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_mac_lsb | input | 8 | Sixth byte of the local station address |
| in_valid | input | 1 | A byte is transferred on this edge |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Marks the final byte of a frame |
| skip_req | output | 1 | One-cycle request to discard the current frame |
| rst_pulse | output | 4 | One-cycle device reset requests (Ethernet, ADC, temperature, DAC) |
| reply_req | output | 1 | One-cycle request to send an initialization-complete reply |
| cmd_valid | output | 1 | One-cycle strobe for a non-reset command code |
| cmd_code | output | 8 | Last non-reset command code |

## Verification
The hardest cases are those where the frame ends at a boundary: on the code byte, on the flag byte, or inside the address field. In each of these the decision and the end of the frame fall on the same byte. The bench sweeps frame lengths from 1 to 20 for both a reset code and a plain code, and under both address outcomes, so that every ending position meets every path. It also inserts idle cycles between bytes, so the index counter is shown to advance only on accepted bytes. Every value of the flag byte, the code byte and the checked address byte is swept in turn, with padding that imitates a second command.

// File: rtl/cmd_rx_pkg.sv
`timescale 1ns/1ps
package cmd_rx_pkg;
    localparam int BYTE_W = 8;
    localparam int FLAG_W = 4;
    localparam logic [BYTE_W-1:0] CODE_RESET = 8'h52;

    typedef struct packed {
        logic [BYTE_W-1:0] code;
        logic              code_seen;
        logic [FLAG_W-1:0] flags;
        logic              flag_seen;
    } cmd_hold_t;

    typedef struct packed {
        logic [FLAG_W-1:0] rst;
        logic              reply;
        logic              cmd_v;
        logic [BYTE_W-1:0] code;
    } cmd_out_t;
endpackage

// File: rtl/rx_pos_track.sv
`timescale 1ns/1ps
module rx_pos_track #(
    parameter int ADDR_BYTES = 6,
    parameter int HDR_BYTES  = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    input  logic last,
    output logic at_check,
    output logic at_code,
    output logic at_flag
);
    localparam int SAT = HDR_BYTES + 2;
    localparam int CW  = $clog2(SAT + 1);

    typedef struct packed {
        logic [CW-1:0] pos;
    } pos_t;

    pos_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (beat) begin
            if (last) begin
                st_d.pos = '0;
            end else if (st_q.pos != CW'(SAT)) begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign at_check = (st_q.pos == CW'(ADDR_BYTES - 1));
    assign at_code  = (st_q.pos == CW'(HDR_BYTES));
    assign at_flag  = (st_q.pos == CW'(HDR_BYTES + 1));
endmodule

// File: rtl/rx_addr_check.sv
`timescale 1ns/1ps
module rx_addr_check
    import cmd_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat,
    input  logic              last,
    input  logic              at_check,
    input  logic [BYTE_W-1:0] data,
    input  logic [BYTE_W-1:0] local_byte,
    output logic              frame_bad,
    output logic              skip
);
    typedef struct packed {
        logic bad;
        logic skip;
    } chk_t;

    chk_t st_d, st_q;
    logic mismatch;

    always_comb begin
        mismatch  = beat && at_check && (data != local_byte);
        st_d.skip = mismatch;
        st_d.bad  = st_q.bad || mismatch;
        if (beat && last) begin
            st_d.bad = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_bad = st_q.bad;
    assign skip      = st_q.skip;
endmodule

// File: rtl/rx_cmd_decode.sv
`timescale 1ns/1ps
module rx_cmd_decode
    import cmd_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat,
    input  logic              last,
    input  logic              at_code,
    input  logic              at_flag,
    input  logic              frame_bad,
    input  logic [BYTE_W-1:0] data,
    output cmd_out_t          out
);
    cmd_hold_t hold_d, hold_q;
    cmd_out_t  out_d, out_q;

    logic [BYTE_W-1:0] code_now;
    logic              code_seen_now;
    logic [FLAG_W-1:0] flags_now;
    logic              flag_seen_now;

    always_comb begin
        hold_d = hold_q;
        out_d  = out_q;
        out_d.rst   = '0;
        out_d.reply = 1'b0;
        out_d.cmd_v = 1'b0;

        code_now      = (beat && at_code) ? data : hold_q.code;
        code_seen_now = hold_q.code_seen || (beat && at_code);
        flags_now     = (beat && at_flag) ? data[FLAG_W-1:0] : hold_q.flags;
        flag_seen_now = hold_q.flag_seen || (beat && at_flag);

        if (beat) begin
            hold_d.code      = code_now;
            hold_d.code_seen = code_seen_now;
            hold_d.flags     = flags_now;
            hold_d.flag_seen = flag_seen_now;
            if (last) begin
                hold_d.code_seen = 1'b0;
                hold_d.flag_seen = 1'b0;
                if (!frame_bad && code_seen_now) begin
                    if (code_now == CODE_RESET) begin
                        if (flag_seen_now) begin
                            out_d.rst   = flags_now;
                            out_d.reply = 1'b1;
                        end
                    end else begin
                        out_d.cmd_v = 1'b1;
                        out_d.code  = code_now;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            out_q  <= '0;
        end else begin
            hold_q <= hold_d;
            out_q  <= out_d;
        end
    end

    assign out = out_q;
endmodule

// File: rtl/cmd_rx_decoder.sv
`timescale 1ns/1ps
module cmd_rx_decoder
    import cmd_rx_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HDR_BYTES  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] local_mac_lsb,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              skip_req,
    output logic [FLAG_W-1:0] rst_pulse,
    output logic              reply_req,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_code
);
    logic     at_check, at_code, at_flag;
    logic     frame_bad;
    cmd_out_t dec_out;

    rx_pos_track #(
        .ADDR_BYTES (ADDR_BYTES),
        .HDR_BYTES  (HDR_BYTES)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (in_valid),
        .last     (in_last),
        .at_check (at_check),
        .at_code  (at_code),
        .at_flag  (at_flag)
    );

    rx_addr_check u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat       (in_valid),
        .last       (in_last),
        .at_check   (at_check),
        .data       (in_data),
        .local_byte (local_mac_lsb),
        .frame_bad  (frame_bad),
        .skip       (skip_req)
    );

    rx_cmd_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (in_valid),
        .last      (in_last),
        .at_code   (at_code),
        .at_flag   (at_flag),
        .frame_bad (frame_bad),
        .data      (in_data),
        .out       (dec_out)
    );

    assign rst_pulse = dec_out.rst;
    assign reply_req = dec_out.reply;
    assign cmd_valid = dec_out.cmd_v;
    assign cmd_code  = dec_out.code;
endmodule

// File: rtl/cmd_rx_decoder_chk.sv
`timescale 1ns/1ps
module cmd_rx_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_last,
    input logic       skip_req,
    input logic [3:0] rst_pulse,
    input logic       reply_req,
    input logic       cmd_valid
);
    AST_SKIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |=> !skip_req); // R2
    AST_SKIP_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> $past(in_valid)); // R2
    AST_SKIP_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> !(reply_req || cmd_valid || (rst_pulse != 4'd0))); // R3
    AST_REPLY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reply_req |=> !reply_req); // R5
    AST_OUT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_req || cmd_valid) |-> $past(in_valid && in_last)); // R9
    AST_CMD_REPLY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && reply_req)); // R11
    AST_RST_NEEDS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pulse != 4'd0) |-> reply_req); // R11
endmodule

bind cmd_rx_decoder cmd_rx_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .skip_req  (skip_req),
    .rst_pulse (rst_pulse),
    .reply_req (reply_req),
    .cmd_valid (cmd_valid)
);

// File: tb/cmd_rx_decoder_tb.sv
`timescale 1ns/1ps
module cmd_rx_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] local_mac_lsb = 8'hA7;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       skip_req;
    logic [3:0] rst_pulse;
    logic       reply_req;
    logic       cmd_valid;
    logic [7:0] cmd_code;

    always #10 clk = ~clk;

    cmd_rx_decoder u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .local_mac_lsb (local_mac_lsb),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_last       (in_last),
        .skip_req      (skip_req),
        .rst_pulse     (rst_pulse),
        .reply_req     (reply_req),
        .cmd_valid     (cmd_valid),
        .cmd_code      (cmd_code)
    );

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [7:0] frm [0:79];
    int  accepted;
    int  skip_cnt, skip_at, reply_cnt, reply_at, rst_cnt, cmd_cnt, cmd_at;
    logic [3:0] rst_seen;
    logic [7:0] code_seen;
    logic [7:0] last_code = 8'h00;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample();
        if (skip_req)  begin skip_cnt++;  skip_at  = accepted - 1; end
        if (reply_req) begin reply_cnt++; reply_at = accepted - 1; end
        if (rst_pulse != 4'd0) begin rst_cnt++; rst_seen = rst_seen | rst_pulse; end
        if (cmd_valid) begin cmd_cnt++; cmd_at = accepted - 1; code_seen = cmd_code; end
    endtask

    task automatic build(input int len, input logic [7:0] b5, input logic [7:0] code,
                         input logic [7:0] flags, input int fill);
        for (int i = 0; i < 80; i++) frm[i] = 8'((i * 37 + fill) & 255);
        frm[5]  = b5;
        frm[14] = code;
        frm[15] = flags;
        frm[16] = 8'h52;
        frm[17] = 8'h0F;
        if (len < 0) frm[0] = 8'h00;
    endtask

    task automatic send(input int len, input bit gaps);
        accepted = 0; skip_cnt = 0; skip_at = -1; reply_cnt = 0; reply_at = -1;
        rst_cnt = 0; cmd_cnt = 0; cmd_at = -1; rst_seen = 4'd0; code_seen = 8'h00;
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk); sample();
                in_valid = 1'b0; in_data = 8'h52; in_last = 1'b1;
            end
            @(negedge clk); sample();
            in_valid = 1'b1; in_data = frm[i]; in_last = (i == len - 1);
            accepted++;
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); sample();
            in_valid = 1'b0; in_last = 1'b0;
        end
    endtask

    // Expected results derived from the requirements alone
    task automatic run_and_check(input int len, input bit gaps, input string tag);
        logic [7:0] b5, code, flags;
        bit  exp_skip, exp_reply, exp_cmd;
        logic [3:0] exp_rst;
        b5 = frm[5]; code = frm[14]; flags = frm[15];
        exp_skip  = (len >= 6) && (b5 != local_mac_lsb);
        exp_reply = !exp_skip && (len >= 16) && (code == 8'h52);
        exp_rst   = exp_reply ? flags[3:0] : 4'd0;
        exp_cmd   = !exp_skip && (len >= 15) && (code != 8'h52);
        send(len, gaps);
        chk(skip_cnt == (exp_skip ? 1 : 0), {tag, " R2 skip count"}, skip_cnt, int'(exp_skip));
        if (exp_skip) chk(skip_at == 5, {tag, " R2 skip timing"}, skip_at, 5);
        chk(reply_cnt == (exp_reply ? 1 : 0), {tag, " R5 R3 reply count"}, reply_cnt, int'(exp_reply));
        if (exp_reply) chk(reply_at == len - 1, {tag, " R5 reply timing"}, reply_at, len - 1);
        chk(rst_seen == exp_rst, {tag, " R5 R6 rst_pulse"}, int'(rst_seen), int'(exp_rst));
        chk(rst_cnt == ((exp_rst != 0) ? 1 : 0), {tag, " R5 rst pulse width"}, rst_cnt, int'(exp_rst != 0));
        chk(cmd_cnt == (exp_cmd ? 1 : 0), {tag, " R9 R8 cmd count"}, cmd_cnt, int'(exp_cmd));
        if (exp_cmd) begin
            chk(code_seen == code && cmd_at == len - 1, {tag, " R9 cmd code"}, int'(code_seen), int'(code));
            last_code = code;
        end
        chk(cmd_code == last_code, {tag, " R9 code hold"}, int'(cmd_code), int'(last_code));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!skip_req && !reply_req && !cmd_valid && rst_pulse == 0 && cmd_code == 0,
            "R1 outputs during reset", int'(skip_req | reply_req | cmd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!skip_req && !reply_req && !cmd_valid && rst_pulse == 0 && cmd_code == 0,
            "R1 outputs after reset", int'(rst_pulse), 0);

        // R5 R6 R7: every flag byte value on a reset command, padding imitates a command
        for (int f = 0; f < 256; f++) begin
            build(64, 8'hA7, 8'h52, 8'(f), f);
            run_and_check(64, (f % 16) == 3, "flags");
        end
        // R9 R4: every code value, header bytes varied
        for (int c = 0; c < 256; c++) begin
            build(64, 8'hA7, 8'(c), 8'h0F, c * 5);
            run_and_check(64, (c % 8) == 5, "code");
        end
        // R2 R3: every checked address byte value against two local bytes
        for (int b = 0; b < 256; b++) begin
            local_mac_lsb = (b < 128) ? 8'hA7 : 8'h3C;
            build(40, 8'(b), (b % 2 == 0) ? 8'h52 : 8'h51, 8'h0B, b);
            run_and_check(40, (b % 4) == 1, "addr");
        end
        local_mac_lsb = 8'hA7;
        // R8 R10: every end position around the boundaries, both outcomes, with and without gaps
        for (int len = 1; len <= 20; len++) begin
            for (int v = 0; v < 8; v++) begin
                build(len, (v[0]) ? 8'hA6 : 8'hA7, (v[1]) ? 8'h51 : 8'h52, 8'h09, len + v);
                run_and_check(len, v[2], "length");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule